// File: doc/BRIEF.md
# SYNC Line Low-Pulse Monitor

This block observes the active-low, synchronous SYNC line that a converter-link receiver returns to its transmitter. It runs on the frame clock. It measures every low excursion of the line in frame clocks and sorts each one into one of three kinds. A two-frame dip means the receiver has signalled a minor error and keeps the link up. A dip longer than five frames plus nine octets means the receiver wants the link re-initialized. Any other length is counted separately, so that it can be investigated.

A low level that starts at reset without a preceding high is treated as code-group synchronization still in progress. It is not counted as an error pulse. If such a low level, or any low pulse, lasts longer than a programmable number of frames, the block raises a loss flag. Saturating counters, the length of the last completed pulse and a sticky re-initialization flag give debug logic a record of link health. A software clear resets the counters and the sticky flag.

The octets-per-frame value `opf` must be at least 1. The large-pulse test works in octets: a pulse of N frame clocks is large when N·opf > 5·opf + 9.

Top module: `sync_err_mon`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: `link_up` equals the value of `sync_n` sampled at the previous clock edge.
- R3: A low pulse that follows a high level and lasts exactly 2 frame clocks increments `small_cnt` by one and leaves `reinit_flag` unchanged.
- R4: A low pulse of N frame clocks with N·opf > 5·opf + 9 increments `large_cnt` by one and sets `reinit_flag`.
- R5: A completed low pulse that is neither small nor large increments `other_cnt` by one. Each completed pulse changes at most one counter.
- R6: On the edge that first samples `sync_n` high after a counted pulse, `last_len` takes the pulse length in frame clocks, saturating at 2^LEN_W−1. Otherwise `last_len` holds its value.
- R7: A low level present since reset, with no high level sampled before it, updates no counter and does not change `last_len` when it ends.
- R8: `loss_flag` is 1 after the edge that samples `sync_n` low for the (loss_tmo+1)-th consecutive time. It stays 1 while the line remains low and returns to 0 on the edge that samples `sync_n` high.
- R9: Each counter saturates at 2^CNT_W−1.
- R10: A cycle with `clr` high sets all three counters and `reinit_flag` to 0 at that edge. This takes priority over a pulse completing at the same edge. `last_len` is not affected by `clr`.
- R11: `reinit_flag` stays 1 until `clr`, whatever `sync_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Observed SYNC line, active low |
| opf | input | OPF_W | Octets per frame (>= 1) |
| loss_tmo | input | TMO_W | Persistent-low timeout in frame clocks |
| clr | input | 1 | Clears counters and re-init flag |
| link_up | output | 1 | Registered SYNC level |
| loss_flag | output | 1 | Line low longer than timeout |
| small_cnt | output | CNT_W | Two-frame pulse count |
| large_cnt | output | CNT_W | Re-init request count |
| other_cnt | output | CNT_W | Unclassified pulse count |
| last_len | output | LEN_W | Length of last counted pulse |
| reinit_flag | output | 1 | Sticky re-init request seen |

## Verification
A wrong run length or a misplaced edge memory shows up as a wrong `last_len`, and as a count landing in the wrong counter. This happens on the first edge that samples the line high again, one cycle after the pulse ends. A mistaken arming state appears when the low level from reset releases: a counter moves when none should. A loss-timer fault appears exactly at the (timeout+1)-th low sample. The reference model compares every output on every cycle, so each of these faults is caught within the same cycle it becomes visible.

// File: rtl/syncmon_pkg.sv
// Shared types for the SYNC low-pulse monitor.
package syncmon_pkg;
    // Classification of a completed low pulse
    typedef enum logic [1:0] {
        EV_SMALL = 2'd0,
        EV_LARGE = 2'd1,
        EV_OTHER = 2'd2
    } ev_kind_t;

    localparam int unsigned N_KINDS = 3;
endpackage

// File: rtl/syncmon_tracker.sv
// Tracks the SYNC level, counts consecutive low samples (saturating),
// arms on a high-to-low transition and flags a pulse end on low-to-high.
// Assumes sync_n is already synchronous to clk.
module syncmon_tracker #(
    parameter int LEN_W = 12,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic [TMO_W-1:0] loss_tmo,
    output logic             sync_q,
    output logic             pulse_end,
    output logic [LEN_W-1:0] end_len,
    output logic             loss_q
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
    localparam int CMP_W = ((LEN_W > TMO_W) ? LEN_W : TMO_W) + 1;

    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] run_inc;
    logic             armed_q;

    // Saturating next value of the low-run counter
    always_comb begin
        run_inc = (run_q == LEN_MAX) ? run_q : run_q + 1'b1;
    end

    // Register level, low run length, arming and loss state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 1'b0;
            run_q   <= '0;
            armed_q <= 1'b0;
            loss_q  <= 1'b0;
        end else begin
            sync_q <= sync_n;
            if (sync_n) begin
                run_q   <= '0;
                armed_q <= 1'b0;
                loss_q  <= 1'b0;
            end else begin
                run_q  <= run_inc;
                loss_q <= CMP_W'(run_inc) > CMP_W'(loss_tmo);
                if (sync_q) begin
                    armed_q <= 1'b1;
                end
            end
        end
    end

    // A counted pulse ends when the line is first seen high again
    always_comb begin
        pulse_end = sync_n & ~sync_q & armed_q;
        end_len   = run_q;
    end
endmodule

// File: rtl/syncmon_classify.sv
// Sorts a finished pulse length into small / large / other.
// Large test in octets: len*opf > 5*opf + 9. Purely combinational.
module syncmon_classify
    import syncmon_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int OPF_W = 8
) (
    input  logic [LEN_W-1:0] len,
    input  logic [OPF_W-1:0] opf,
    output ev_kind_t         kind
);
    localparam int PW = LEN_W + OPF_W + 1;

    logic [PW-1:0] len_octets;
    logic [PW-1:0] big_thr;

    // Pulse length and threshold in octet units
    always_comb begin
        len_octets = PW'(len) * PW'(opf);
        big_thr    = PW'(opf) * PW'(5) + PW'(9);
    end

    // Exactly two frames wins; the two tests cannot overlap anyway
    always_comb begin
        if (len == LEN_W'(2)) begin
            kind = EV_SMALL;
        end else if (len_octets > big_thr) begin
            kind = EV_LARGE;
        end else begin
            kind = EV_OTHER;
        end
    end
endmodule

// File: rtl/syncmon_satcnt.sv
// Saturating event counter with synchronous clear; clear wins over inc.
module syncmon_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] Q_MAX = {W{1'b1}};

    // Count up to the ceiling, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc && q != Q_MAX) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/sync_err_mon.sv
// SYNC line low-pulse monitor, frame-clock domain.
// Measures each low pulse preceded by a high level, classifies it and
// keeps saturating counters, the last length and a sticky re-init flag.
// Assumes opf >= 1 and sync_n synchronous to clk.
module sync_err_mon
    import syncmon_pkg::*;
#(
    parameter int OPF_W = 8,
    parameter int LEN_W = 12,
    parameter int TMO_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic [OPF_W-1:0] opf,
    input  logic [TMO_W-1:0] loss_tmo,
    input  logic             clr,
    output logic             link_up,
    output logic             loss_flag,
    output logic [CNT_W-1:0] small_cnt,
    output logic [CNT_W-1:0] large_cnt,
    output logic [CNT_W-1:0] other_cnt,
    output logic [LEN_W-1:0] last_len,
    output logic             reinit_flag
);
    logic             pulse_end;
    logic [LEN_W-1:0] end_len;
    ev_kind_t         kind;
    logic [N_KINDS-1:0] ev_hit;
    logic [CNT_W-1:0] cnt_q [N_KINDS];

    syncmon_tracker #(.LEN_W(LEN_W), .TMO_W(TMO_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .loss_tmo(loss_tmo),
        .sync_q(link_up), .pulse_end(pulse_end), .end_len(end_len),
        .loss_q(loss_flag)
    );

    syncmon_classify #(.LEN_W(LEN_W), .OPF_W(OPF_W)) u_cls (
        .len(end_len), .opf(opf), .kind(kind)
    );

    // One counter per pulse kind, indexed by the enum value
    for (genvar g = 0; g < N_KINDS; g++) begin : g_cnt
        assign ev_hit[g] = pulse_end && (kind == ev_kind_t'(g));
        syncmon_satcnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr), .inc(ev_hit[g]),
            .q(cnt_q[g])
        );
    end

    assign small_cnt = cnt_q[EV_SMALL];
    assign large_cnt = cnt_q[EV_LARGE];
    assign other_cnt = cnt_q[EV_OTHER];

    // Capture the length of every counted pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_len <= '0;
        end else if (pulse_end) begin
            last_len <= end_len;
        end
    end

    // Sticky re-init request, cleared only by clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            reinit_flag <= 1'b0;
        end else if (ev_hit[EV_LARGE]) begin
            reinit_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_err_mon_chk.sv
// Checker for sync_err_mon: port-level temporal properties.
module sync_err_mon_chk #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_n,
    input logic             clr,
    input logic             link_up,
    input logic             loss_flag,
    input logic [CNT_W-1:0] small_cnt,
    input logic [CNT_W-1:0] large_cnt,
    input logic [CNT_W-1:0] other_cnt,
    input logic [LEN_W-1:0] last_len,
    input logic             reinit_flag
);
    localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};

    // R2: registered line level
    p_link_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> link_up == $past(sync_n));

    // R8: a high sample clears the loss flag
    p_loss_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sync_n) |-> !loss_flag);

    // R11: sticky until clr
    p_reinit_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(reinit_flag) && !$past(clr) |-> reinit_flag);

    // R4: flag rises only with a large count step
    p_reinit_large_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(reinit_flag) |-> large_cnt != $past(large_cnt));

    // R10: clear empties counters and flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr) |->
        small_cnt == '0 && large_cnt == '0 && other_cnt == '0 && !reinit_flag);

    // R9: counters never wrap, step by at most one
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(clr) |->
        small_cnt >= $past(small_cnt) && large_cnt >= $past(large_cnt) &&
        other_cnt >= $past(other_cnt) &&
        (small_cnt - $past(small_cnt)) <= CNT_W'(1) &&
        (other_cnt - $past(other_cnt)) <= CNT_W'(1));

    // R5: one counter per pulse at most
    p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(clr) |->
        $countones({small_cnt != $past(small_cnt), large_cnt != $past(large_cnt),
                    other_cnt != $past(other_cnt)}) <= 1);

    // R3: small step means a two-frame pulse
    p_small_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(clr) && small_cnt != $past(small_cnt) |->
        last_len == LEN_W'(2));

    // R6: length changes only right after a low-to-high step
    p_len_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && last_len != $past(last_len) |->
        $past(sync_n) && !$past(sync_n, 2));

    // R9: saturated counter stays put without clear
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(small_cnt) == C_MAX && !$past(clr) |->
        small_cnt == C_MAX);
endmodule

bind sync_err_mon sync_err_mon_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .clr(clr),
    .link_up(link_up), .loss_flag(loss_flag), .small_cnt(small_cnt),
    .large_cnt(large_cnt), .other_cnt(other_cnt), .last_len(last_len),
    .reinit_flag(reinit_flag)
);

// File: tb/sim_sync_err_mon.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks per requirement.
module sim_sync_err_mon;
    localparam int OPF_W = 8;
    localparam int LEN_W = 12;
    localparam int TMO_W = 16;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int LMAX  = (1 << LEN_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b0;
    logic [OPF_W-1:0] opf = 8'd4;
    logic [TMO_W-1:0] loss_tmo = 16'd20;
    logic clr = 1'b0;
    logic link_up, loss_flag, reinit_flag;
    logic [CNT_W-1:0] small_cnt, large_cnt, other_cnt;
    logic [LEN_W-1:0] last_len;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    sync_err_mon #(.OPF_W(OPF_W), .LEN_W(LEN_W), .TMO_W(TMO_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .opf(opf), .loss_tmo(loss_tmo),
        .clr(clr), .link_up(link_up), .loss_flag(loss_flag), .small_cnt(small_cnt),
        .large_cnt(large_cnt), .other_cnt(other_cnt), .last_len(last_len),
        .reinit_flag(reinit_flag)
    );

    // Reference model state
    int m_link, m_loss, m_small, m_large, m_other, m_len, m_reinit;
    int m_run, m_prev, m_armed;
    bit live = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Model update from the requirement text
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_link = 0; m_loss = 0; m_small = 0; m_large = 0; m_other = 0;
            m_len = 0; m_reinit = 0; m_run = 0; m_prev = 0; m_armed = 0;
        end else begin
            m_link = sync_n;
            if (sync_n) begin
                if (m_prev == 0 && m_armed == 1) begin
                    m_len = m_run;
                    if (m_run == 2) m_small = (m_small < CMAX) ? m_small + 1 : m_small;
                    else if (m_run * opf > 5 * opf + 9) begin
                        m_large = (m_large < CMAX) ? m_large + 1 : m_large;
                        m_reinit = 1;
                    end else m_other = (m_other < CMAX) ? m_other + 1 : m_other;
                end
                m_run = 0; m_armed = 0; m_loss = 0;
            end else begin
                if (m_prev == 1) m_armed = 1;
                m_run = (m_run < LMAX) ? m_run + 1 : m_run;
                m_loss = (m_run > loss_tmo) ? 1 : 0;
            end
            if (clr) begin
                m_small = 0; m_large = 0; m_other = 0; m_reinit = 0;
            end
            m_prev = sync_n;
        end
        live = 1'b1;
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live) begin
            chk("R2 link_up", int'(link_up), m_link);
            chk("R8 loss_flag", int'(loss_flag), m_loss);
            chk("R3 small_cnt", int'(small_cnt), m_small);
            chk("R4 large_cnt", int'(large_cnt), m_large);
            chk("R5 other_cnt", int'(other_cnt), m_other);
            chk("R6 last_len", int'(last_len), m_len);
            chk("R11 reinit_flag", int'(reinit_flag), m_reinit);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int low, input int high);
        @(negedge clk); sync_n = 1'b0;
        wait_cyc(low - 1);
        @(negedge clk); sync_n = 1'b1;
        wait_cyc(high);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        wait (cyc > 50000);
        checks++; fails++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        finish_run();
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        chk("R1 reset", int'({link_up, loss_flag, reinit_flag}), 0);
        chk("R1 reset counts", int'(small_cnt) + int'(large_cnt) + int'(other_cnt) + int'(last_len), 0);
        rst_n = 1'b1;
        // R7: low from reset, then high: nothing counted
        wait_cyc(6);
        sync_n = 1'b1;
        wait_cyc(4);
        chk("R7 no count", int'(small_cnt) + int'(large_cnt) + int'(other_cnt), 0);
        chk("R7 last_len", int'(last_len), 0);
        // opf=4: threshold 29 octets -> large from 8 frames
        pulse(1, 4); pulse(2, 4); pulse(3, 4); pulse(7, 4); pulse(8, 4);
        chk("R3 small", int'(small_cnt), 1);
        chk("R4 large", int'(large_cnt), 1);
        chk("R5 other", int'(other_cnt), 3);
        chk("R6 len", int'(last_len), 8);
        wait_cyc(10);
        chk("R11 sticky", int'(reinit_flag), 1);
        // R10: clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R10 cleared", int'(small_cnt) + int'(large_cnt) + int'(other_cnt) + int'(reinit_flag), 0);
        chk("R10 len kept", int'(last_len), 8);
        // opf=1: threshold 14 octets
        opf = 8'd1;
        pulse(14, 3);
        chk("R5 edge other", int'(other_cnt), 1);
        pulse(15, 3);
        chk("R4 edge large", int'(large_cnt), 1);
        // R8: persistent low
        @(negedge clk); sync_n = 1'b0;
        wait_cyc(20);
        chk("R8 not yet", int'(loss_flag), 0);
        wait_cyc(1);
        chk("R8 set", int'(loss_flag), 1);
        sync_n = 1'b1;
        wait_cyc(1);
        chk("R8 clear", int'(loss_flag), 0);
        wait_cyc(3);
        // R10: clr on the same edge as a pulse end
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        @(negedge clk); sync_n = 1'b0;
        @(negedge clk);
        @(negedge clk); sync_n = 1'b1; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R10 priority", int'(small_cnt), 0);
        chk("R6 len under clr", int'(last_len), 2);
        // R9: saturation
        for (int k = 0; k < CMAX + 2; k++) pulse(2, 2);
        chk("R9 saturate", int'(small_cnt), CMAX);
        wait_cyc(2);
        finish_run();
    end
endmodule